// File: doc/BRIEF.md
# Variable-Latency Pipeline Interlock Controller

This block is the timing and control core of an in-order five-stage pipeline with the stages fetch, decode, execute, memory and write-back. It models when each instruction occupies each stage. It does not model arithmetic, register contents or memory data. Every stage takes one cycle except execute. Execute holds an ADD for one cycle and a MUL for two consecutive cycles. Decode only decodes. Source operands are read as an instruction enters execute, so every hazard decision is made at the entry to execute.

A run starts with a one-cycle `start` pulse. The pulse latches a program of up to 16 instructions. Each instruction is one opcode bit and one flag that says it consumes the result of the instruction just before it. The same pulse samples the forwarding mode. Without forwarding, a dependent instruction waits for its producer to finish write-back. With forwarding, it may enter execute in the cycle right after its producer's last execute cycle. A multi-cycle MUL also blocks execute by itself, and the controller inserts bubbles for both reasons.

The controller shows which stages hold an instruction in each cycle, and which instruction each one is. It pulses a retire strobe, with the instruction index, as each instruction writes back. When the last instruction has written back, it raises `done` and holds the total cycle count.

Top module: `ilk_interlock_ctrl`

## Requirements
- R1: After synchronous active-high reset, `stage_valid` is all zero, `cycle_count` is 0, and `busy` and `done` are low.
- R2: The first fetch of a run is cycle 1. For a program of n ADDs with no dependence between them, the last write-back, and so the final `cycle_count`, is cycle n+4. A single ADD therefore finishes in cycle 5.
- R3: Bit i of `prog_op` set to 1 makes instruction i a MUL, which occupies execute for two consecutive cycles. Bit i set to 0 makes it an ADD, which occupies execute for one cycle. For a program with no effective dependences, the total is 4 plus the sum of the execute latencies.
- R4: Bit i of `prog_dep` set to 1 marks instruction i (for i > 0) as dependent on instruction i-1. In no-forwarding mode, a dependent instruction enters execute no earlier than the cycle after its producer's write-back cycle.
- R5: In forwarding mode, a dependent instruction may enter execute in the cycle right after its producer's final execute cycle. Dependence then adds no cycles beyond the occupancy of execute.
- R6: The program MUL-after-ADD alternating over eight instructions (ADD first), each instruction after the first dependent, finishes in cycle 30 without forwarding and in cycle 16 with forwarding.
- R7: `retire` pulses once per instruction, during its write-back cycle, with `retire_idx` ascending from 0. During that cycle `cycle_count` equals the write-back cycle number.
- R8: `fwd_en` is sampled only at an accepted start. Changing it during a run does not change the timing of that run.
- R9: `start` is ignored while `busy` is high. It is also ignored when `prog_len` is 0 or greater than 16. An ignored start leaves `busy`, `done` and `cycle_count` unchanged.
- R10: Bubbles never retire. A run of n instructions produces exactly n retire strobes.
- R11: After the last write-back, `done` is high, `busy` is low, and `cycle_count` keeps the total until the next accepted start.
- R12: `stage_valid` bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 write-back. A hazard stall holds fetch and decode and sends a bubble into execute. The second cycle of a MUL holds fetch and decode and sends a bubble into memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the program on the program inputs |
| fwd_en | input | 1 | Forwarding mode, sampled at start |
| prog_op | input | 16 | Opcode per instruction, 1 = MUL, 0 = ADD |
| prog_dep | input | 16 | Per-instruction dependence on the previous instruction |
| prog_len | input | 5 | Number of instructions, 1 to 16 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |
| cycle_count | output | 8 | Current cycle number; the total after completion |
| retire | output | 1 | An instruction is in write-back this cycle |
| retire_idx | output | 4 | Index of the retiring instruction |
| stage_valid | output | 5 | Per-stage occupancy, bit 0 fetch to bit 4 write-back |
| stage_idx | output | 20 | Per-stage instruction index, 4 bits per stage, fetch lowest |

## Verification
Any wrong internal state shows up as a wrong write-back cycle. Suppose the decode stall misjudges a producer, or a MUL leaves execute after one cycle. Then the next retire strobe carries a `cycle_count` that differs from the arithmetic schedule, in the cycle that instruction writes back, which is at most a few cycles after the fault. A lost or duplicated slot appears as an out-of-order `retire_idx` or a wrong strobe count. Occupancy samples in chosen cycles expose a misplaced bubble before it reaches write-back.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    localparam int unsigned PROG_MAX = 16;
    localparam int unsigned IDX_W    = $clog2(PROG_MAX);
    localparam int unsigned LEN_W    = $clog2(PROG_MAX + 1);
    localparam int unsigned CNT_W    = 8;
    localparam int unsigned N_STAGES = 5;

    localparam int SI_IF  = 0;
    localparam int SI_ID  = 1;
    localparam int SI_EX  = 2;
    localparam int SI_MEM = 3;
    localparam int SI_WB  = 4;

    typedef struct packed {
        logic             valid;
        logic             mul;
        logic             dep;
        logic [IDX_W-1:0] idx;
    } slot_t;

    localparam slot_t BUBBLE = '0;

    function automatic slot_t make_slot(input logic [PROG_MAX-1:0] ops,
                                        input logic [PROG_MAX-1:0] deps,
                                        input logic [IDX_W-1:0]    i);
        slot_t s;
        s.valid = 1'b1;
        s.mul   = ops[i];
        s.dep   = deps[i];
        s.idx   = i;
        return s;
    endfunction
endpackage

// File: rtl/ilk_fetch.sv
module ilk_fetch
    import ilk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [PROG_MAX-1:0] prog_op,
    input  logic [PROG_MAX-1:0] prog_dep,
    input  logic [LEN_W-1:0]    prog_len,
    input  logic                advance,
    output slot_t               head,
    output logic                avail,
    output logic [IDX_W-1:0]    last_idx
);
    logic [PROG_MAX-1:0] ops_q;
    logic [PROG_MAX-1:0] deps_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ops_q  <= '0;
            deps_q <= '0;
            len_q  <= '0;
            pc     <= '0;
        end else if (load) begin
            ops_q  <= prog_op;
            deps_q <= prog_dep;
            len_q  <= prog_len;
            pc     <= LEN_W'(1);
        end else if (advance) begin
            pc <= pc + 1'b1;
        end
    end

    assign avail    = (pc < len_q);
    assign head     = make_slot(ops_q, deps_q, IDX_W'(pc));
    assign last_idx = IDX_W'(len_q - 1'b1);
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
(
    input  slot_t st_id,
    input  slot_t st_ex,
    input  slot_t st_mem,
    input  logic  ex_second,
    input  logic  fwd,
    output logic  ex_hold,
    output logic  dep_stall,
    output logic  id_move
);
    // A MUL in its first execute cycle keeps the stage for one more cycle.
    assign ex_hold = st_ex.valid && st_ex.mul && !ex_second;

    // Without forwarding the producer (the next older instruction) must have
    // left execute and memory; being in write-back now is early enough.
    assign dep_stall = st_id.valid && st_id.dep && !fwd &&
                       (st_ex.valid || st_mem.valid);

    assign id_move = st_id.valid && !ex_hold && !dep_stall;
endmodule

// File: rtl/ilk_cycle_ctr.sv
module ilk_cycle_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_one,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_one) begin
            count <= W'(1);
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ilk_interlock_ctrl.sv
module ilk_interlock_ctrl
    import ilk_pkg::*;
#(
    parameter int unsigned CNT_BITS = ilk_pkg::CNT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      fwd_en,
    input  logic [PROG_MAX-1:0]       prog_op,
    input  logic [PROG_MAX-1:0]       prog_dep,
    input  logic [LEN_W-1:0]          prog_len,
    output logic                      busy,
    output logic                      done,
    output logic [CNT_BITS-1:0]       cycle_count,
    output logic                      retire,
    output logic [IDX_W-1:0]          retire_idx,
    output logic [N_STAGES-1:0]       stage_valid,
    output logic [N_STAGES*IDX_W-1:0] stage_idx
);
    slot_t stg [N_STAGES];
    logic  ex_second;
    logic  fwd_q;

    logic  len_ok, accept, finish;
    logic  ex_hold, dep_stall, id_move, id_load, if_load, fetch_adv;
    slot_t head;
    logic  avail;
    logic  [IDX_W-1:0] last_idx;

    assign len_ok = (prog_len != '0) && (prog_len <= LEN_W'(PROG_MAX));
    assign accept = !busy && start && len_ok;
    assign finish = busy && stg[SI_WB].valid && (stg[SI_WB].idx == last_idx);

    ilk_hazard u_haz (
        .st_id     (stg[SI_ID]),
        .st_ex     (stg[SI_EX]),
        .st_mem    (stg[SI_MEM]),
        .ex_second (ex_second),
        .fwd       (fwd_q),
        .ex_hold   (ex_hold),
        .dep_stall (dep_stall),
        .id_move   (id_move)
    );

    assign id_load   = !stg[SI_ID].valid || id_move;
    assign if_load   = id_load || !stg[SI_IF].valid;
    assign fetch_adv = busy && !finish && if_load && avail;

    ilk_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .prog_op  (prog_op),
        .prog_dep (prog_dep),
        .prog_len (prog_len),
        .advance  (fetch_adv),
        .head     (head),
        .avail    (avail),
        .last_idx (last_idx)
    );

    ilk_cycle_ctr #(.W(CNT_BITS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load_one (accept),
        .inc      (busy && !finish),
        .count    (cycle_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_STAGES; s++) stg[s] <= BUBBLE;
            ex_second <= 1'b0;
            fwd_q     <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else if (!busy) begin
            if (accept) begin
                for (int s = 0; s < N_STAGES; s++) stg[s] <= BUBBLE;
                stg[SI_IF] <= make_slot(prog_op, prog_dep, '0);
                ex_second  <= 1'b0;
                fwd_q      <= fwd_en;
                busy       <= 1'b1;
                done       <= 1'b0;
            end
        end else if (finish) begin
            for (int s = 0; s < N_STAGES; s++) stg[s] <= BUBBLE;
            ex_second <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b1;
        end else begin
            stg[SI_WB] <= stg[SI_MEM];
            if (ex_hold) begin
                stg[SI_MEM] <= BUBBLE;
                ex_second   <= 1'b1;
            end else begin
                stg[SI_MEM] <= stg[SI_EX];
                stg[SI_EX]  <= id_move ? stg[SI_ID] : BUBBLE;
                ex_second   <= 1'b0;
            end
            if (id_load) stg[SI_ID] <= stg[SI_IF];
            if (if_load) stg[SI_IF] <= avail ? head : BUBBLE;
        end
    end

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_occ
            assign stage_valid[g]                 = stg[g].valid;
            assign stage_idx[g*IDX_W +: IDX_W]    = stg[g].idx;
        end
    endgenerate

    assign retire     = stg[SI_WB].valid;
    assign retire_idx = stg[SI_WB].idx;
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker
    import ilk_pkg::*;
#(
    parameter int unsigned CNT_BITS = ilk_pkg::CNT_W
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [CNT_BITS-1:0] cycle_count,
    input logic                retire,
    input logic [IDX_W-1:0]    retire_idx,
    input logic [N_STAGES-1:0] stage_valid
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stage_valid == '0 && cycle_count == '0 && !busy && !done));

    // R10
    a_r10_retire_only_busy: assert property (@(posedge clk) disable iff (rst)
        retire |-> busy);

    // R11
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!retire && !busy));

    // R11
    a_r11_idle_count_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(cycle_count));

    // R7
    a_r7_retire_in_order: assert property (@(posedge clk) disable iff (rst)
        (retire && $past(retire)) |-> (retire_idx == IDX_W'($past(retire_idx) + 1'b1)));

    // R9
    a_r9_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (cycle_count != CNT_BITS'(1)));
endmodule

bind ilk_interlock_ctrl ilk_checker #(.CNT_BITS(CNT_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .cycle_count (cycle_count),
    .retire      (retire),
    .retire_idx  (retire_idx),
    .stage_valid (stage_valid)
);

// File: tb/tb_ilk_interlock_ctrl.sv
module tb_ilk_interlock_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        fwd_en = 1'b0;
    logic [15:0] prog_op = '0;
    logic [15:0] prog_dep = '0;
    logic [4:0]  prog_len = '0;
    logic        busy, done, retire;
    logic [7:0]  cycle_count;
    logic [3:0]  retire_idx;
    logic [4:0]  stage_valid;
    logic [19:0] stage_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_wb [16];
    logic [4:0] occ_log [0:127];

    always #2 clk = ~clk;

    ilk_interlock_ctrl dut (
        .clk(clk), .rst(rst), .start(start), .fwd_en(fwd_en),
        .prog_op(prog_op), .prog_dep(prog_dep), .prog_len(prog_len),
        .busy(busy), .done(done), .cycle_count(cycle_count),
        .retire(retire), .retire_idx(retire_idx),
        .stage_valid(stage_valid), .stage_idx(stage_idx)
    );

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Arithmetic schedule of write-back cycles.
    function automatic void calc(input logic [15:0] ops, input logic [15:0] deps,
                                 input int n, input bit fw);
        int prev_end = 0;
        for (int i = 0; i < n; i++) begin
            int s = i + 3;
            int e;
            if (i > 0 && prev_end + 1 > s) s = prev_end + 1;
            if (i > 0 && deps[i] && !fw && prev_end + 3 > s) s = prev_end + 3;
            e = s + (ops[i] ? 2 : 1) - 1;
            exp_wb[i] = e + 2;
            prev_end = e;
        end
    endfunction

    // mode 0: plain, 1: flip fwd_en during run (R8), 2: restart attempt (R9)
    task automatic run_prog(input logic [15:0] ops, input logic [15:0] deps,
                            input int n, input bit fw, input int mode);
        string tag;
        bit anydep = 0, anymul = 0, got = 0;
        int nret = 0;
        for (int i = 0; i < n; i++) begin
            if (ops[i]) anymul = 1;
            if (i > 0 && deps[i]) anydep = 1;
        end
        if (mode == 1) tag = "R8";
        else if (mode == 2) tag = "R9";
        else if (fw) tag = "R5";
        else if (anydep) tag = "R4";
        else if (anymul) tag = "R3";
        else tag = "R2";
        calc(ops, deps, n, fw);
        for (int c = 0; c < 128; c++) occ_log[c] = '0;
        @(negedge clk);
        prog_op = ops; prog_dep = deps; prog_len = 5'(n); fwd_en = fw; start = 1'b1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            if (mode == 1 && k == 2) fwd_en = !fw;
            if (mode == 2 && k == 3) begin
                start = 1'b1; prog_len = 5'd1; prog_op = 16'hFFFF; prog_dep = '0;
            end
            if (mode == 2 && k == 4) start = 1'b0;
            if (done) begin got = 1; break; end
            if (k + 1 < 128) occ_log[k + 1] = stage_valid;
            if (retire) begin
                chk("R7", "retire index", int'(retire_idx), nret);
                if (nret < n) chk("R7", "retire cycle", int'(cycle_count), exp_wb[nret]);
                nret++;
            end
        end
        start = 1'b0;
        if (!got) begin
            n_tests++; n_fail++;
            $display("FAIL %s run timeout: actual 0 expected 1", tag);
        end else begin
            chk(tag, "total cycles", int'(cycle_count), exp_wb[n-1]);
            chk("R10", "retire strobes", nret, n);
        end
    endtask

    initial begin
        #720000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1234_5678;
        logic [7:0]  held;
        repeat (3) @(negedge clk);
        chk("R1", "stage_valid", int'(stage_valid), 0);
        chk("R1", "cycle_count", int'(cycle_count), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        rst = 1'b0;

        // R6 with occupancy probes (R12)
        run_prog(16'b1010_1010, 16'b1111_1110, 8, 1'b0, 0);
        chk("R6", "alt no-fwd total", int'(cycle_count), 30);
        chk("R12", "cycle1 occupancy", int'(occ_log[1]), 5'b00001);
        chk("R12", "stall bubble in EX", int'(occ_log[4]), 5'b01011);
        run_prog(16'b1010_1010, 16'b1111_1110, 8, 1'b1, 0);
        chk("R6", "alt fwd total", int'(cycle_count), 16);
        chk("R12", "MUL bubble in MEM", int'(occ_log[5]), 5'b10111);

        // R2 single ADD
        run_prog(16'h0, 16'h0, 1, 1'b0, 0);
        chk("R2", "single ADD total", int'(cycle_count), 5);

        // R11 hold after completion
        held = cycle_count;
        repeat (5) @(negedge clk);
        chk("R11", "count held", int'(cycle_count), int'(held));
        chk("R11", "done held", int'(done), 1);
        chk("R11", "busy low", int'(busy), 0);

        // R9 invalid lengths ignored
        prog_len = 5'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "len 0 busy", int'(busy), 0);
        chk("R9", "len 0 count", int'(cycle_count), int'(held));
        prog_len = 5'd17; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "len 17 busy", int'(busy), 0);
        chk("R9", "len 17 done", int'(done), 1);

        // Exhaustive sweep of short programs in both modes
        for (int n = 1; n <= 4; n++)
            for (int code = 0; code < (1 << (2 * n)); code++)
                for (int f = 0; f < 2; f++) begin
                    logic [15:0] o = 16'(code) & 16'((1 << n) - 1);
                    logic [15:0] d = 16'(code >> n);
                    run_prog(o, d, n, f[0], 0);
                end

        // Long programs: all-dependent MUL chain and pseudo-random mixes
        run_prog(16'hFFFF, 16'hFFFF, 16, 1'b0, 0);
        chk("R4", "MUL chain total", int'(cycle_count), 66);
        run_prog(16'hFFFF, 16'hFFFF, 16, 1'b1, 0);
        chk("R5", "MUL chain fwd total", int'(cycle_count), 36);
        for (int r = 0; r < 20; r++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            run_prog(lf[15:0], lf[31:16], 16, r[0], 0);
        end

        // R8 and R9 during runs
        run_prog(16'b1010_1010, 16'b1111_1110, 8, 1'b0, 1);
        chk("R8", "fwd flipped mid-run", int'(cycle_count), 30);
        run_prog(16'b1010_1010, 16'b1111_1110, 8, 1'b1, 1);
        chk("R8", "fwd flipped mid-run", int'(cycle_count), 16);
        run_prog(16'b0110, 16'b0100, 4, 1'b0, 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule